// File: doc/BRIEF.md
# Flash Page-Buffer Programming Controller

This block sits between a CPU's byte-wide register port and a non-volatile memory array. Software first clears a 64-byte staging buffer. It then points a buffer index at a slot and pushes bytes through a data register. Each push stores the byte, marks that slot as updated and advances the index. When the buffer holds the wanted bytes, software writes one of two start commands. One programs only the marked slots of the addressed page. The other erases the whole page first and then programs the marked slots, so every unmarked byte reads as FFh afterwards.

While a cycle runs, the controller holds the CPU in a stall state and blocks every register write. It drives a plain strobe interface toward the array. The erase strobe stays high for a set number of cycles, and the program strobe stays high for a set number of cycles per marked byte. The array can raise a fault line at any time. A fault aborts the cycle and sets an error flag, and software must then start again by clearing the buffer.

Top module: `fpb_ctrl`

## Requirements
- R1: After reset the status register (select 0) reads 00h, both address registers (select 1 low, select 2 high) read 00h, the data register (select 3) reads 00h, and `cpu_stall`, `arr_erase` and `arr_prog` are low.
- R2: Writing command 00h to select 0 clears every buffer byte to 00h, clears every update flag, and clears the error and done status bits.
- R3: A write to select 3 stores the byte in the slot given by bits 5:0 of the low address register and sets that slot's update flag. It then increments bits 5:0, which wrap from 63 to 0 and leave bits 7:6 unchanged. Reading select 3 returns the buffer byte at the current index.
- R4: During a cycle, `arr_page` equals {high address register, low address register bits 7:6}.
- R5: Command 48h starts a program-only cycle. The controller visits slots 0 to 63 in ascending order. A slot with its flag set holds `arr_prog` high for PROG_CYCLES cycles, with `arr_offset` and `arr_wdata` giving that slot and its byte. An unflagged slot takes one cycle. `arr_erase` stays low.
- R6: Command 68h first holds `arr_erase` high for ERASE_CYCLES cycles and then performs the slot pass of R5.
- R7: Status bit 7 and `cpu_stall` go high in the cycle after a start command and stay high for the whole cycle, and no longer. When the cycle completes normally, status bit 1 (done) is set.
- R8: A command value other than 00h, 48h or 68h written while idle sets status bit 0 (error) and starts no cycle.
- R9: All register writes, including commands, are ignored while a cycle runs.
- R10: `arr_fault` high during a cycle ends it on the next clock edge. Status bit 0 is set and bit 1 stays clear.
- R11: Status bit 4 reads 1 after an erase-then-program start and 0 after a program-only start. Status bit 6 reads 1 while any update flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 command/status, 1 address low, 2 address high, 3 data |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| cpu_stall | output | 1 | Holds the CPU while a cycle runs |
| arr_erase | output | 1 | Page erase strobe |
| arr_prog | output | 1 | Byte program strobe |
| arr_page | output | 10 | Target page address |
| arr_offset | output | 6 | Byte slot being programmed |
| arr_wdata | output | 8 | Byte being programmed |
| arr_fault | input | 1 | Array fault, aborts the running cycle |

## Verification
On every cycle, the assertions check the following. The erase and program strobes are never high together, and neither is high without a stall. A data write moves only the six index bits, by exactly one. Register writes during a stall leave the address registers untouched. A bad command or a fault lands in the error state with the stall released. Only the bench's scenarios can show the rest. These are the length of each cycle for a given set of marked slots, the final contents of the page, index wrap-around, the clearing effect of the buffer-clear command, and the status encodings after each kind of cycle.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_AHI  = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  localparam logic [7:0] OP_CLEAR  = 8'h00;
  localparam logic [7:0] OP_PROG   = 8'h48;
  localparam logic [7:0] OP_ERPROG = 8'h68;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ERASE = 2'd1,
    SQ_WRITE = 2'd2
  } seq_state_e;

  // Advance the slot index held in the low iw bits; upper bits untouched.
  function automatic logic [7:0] step_index(input logic [7:0] a, input int unsigned iw);
    logic [7:0] mask;
    mask = 8'((9'd1 << iw) - 9'd1);
    return (a & ~mask) | (8'(a + 8'd1) & mask);
  endfunction

  function automatic logic [7:0] pack_status(input logic busy, input logic staged,
                                             input logic er_mode, input logic done,
                                             input logic err);
    return {busy, staged, 1'b0, er_mode, 2'b00, done, err};
  endfunction

endpackage

// File: rtl/fpb_regs.sv
module fpb_regs #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_alo,
  input  logic              wr_ahi,
  input  logic              wr_dat,
  input  logic [7:0]        wdata,
  output logic [7:0]        alo,
  output logic [7:0]        ahi,
  output logic [IDX_W-1:0]  idx,
  output logic [PAGE_W-1:0] page
);
  import fpb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alo <= 8'h00;
      ahi <= 8'h00;
    end else begin
      if (wr_alo)      alo <= wdata;
      else if (wr_dat) alo <= step_index(alo, IDX_W);
      if (wr_ahi)      ahi <= wdata;
    end
  end

  assign idx  = alo[IDX_W-1:0];
  assign page = {ahi, alo[7:IDX_W]};

  // R3: a data push moves only the index bits, by one
  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat && !wr_alo |=> (alo[7:IDX_W] == $past(alo[7:IDX_W])) &&
                          (alo[IDX_W-1:0] == IDX_W'($past(alo[IDX_W-1:0]) + 1'b1)));

endmodule

// File: rtl/fpb_buffer.sv
module fpb_buffer #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned IDX_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wdata,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  input  logic [IDX_W-1:0]      pg_idx,
  output logic [7:0]            pg_data,
  output logic [PAGE_BYTES-1:0] flags
);
  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] hit;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    assign hit[g] = wr && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < PAGE_BYTES; i++) mem[i] <= 8'h00;
      flags <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (hit[i]) begin
          mem[i]   <= wdata;
          flags[i] <= 1'b1;
        end
      end
    end
  end

  assign rd_data = mem[rd_idx];
  assign pg_data = mem[pg_idx];

  // R2: clear leaves no flag behind
  a_r2_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> flags == '0);

endmodule

// File: rtl/fpb_seq.sv
module fpb_seq #(
  parameter int unsigned PAGE_BYTES   = 64,
  parameter int unsigned IDX_W        = 6,
  parameter int unsigned ERASE_CYCLES = 20,
  parameter int unsigned PROG_CYCLES  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_erase,
  input  logic                  fault,
  input  logic [PAGE_BYTES-1:0] flags,
  output logic                  busy,
  output logic                  done_pulse,
  output logic                  abort_pulse,
  output logic                  arr_erase,
  output logic                  arr_prog,
  output logic [IDX_W-1:0]      slot
);
  import fpb_pkg::*;

  localparam int unsigned CMAX  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int unsigned CNT_W = $clog2(CMAX + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAGE_BYTES - 1);

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             slot_adv;
  logic             erase_end;

  assign erase_end = (st == SQ_ERASE) && (cnt == CNT_W'(ERASE_CYCLES - 1));
  assign slot_adv  = (st == SQ_WRITE) &&
                     (!flags[slot] || (cnt == CNT_W'(PROG_CYCLES - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      cnt  <= '0;
      slot <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st   <= start_erase ? SQ_ERASE : SQ_WRITE;
          cnt  <= '0;
          slot <= '0;
        end
        SQ_ERASE: begin
          if (fault) st <= SQ_IDLE;
          else if (erase_end) begin
            st  <= SQ_WRITE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SQ_WRITE: begin
          if (fault) st <= SQ_IDLE;
          else if (slot_adv) begin
            cnt <= '0;
            if (slot == LAST) st <= SQ_IDLE;
            else              slot <= slot + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy        = (st != SQ_IDLE);
  assign arr_erase   = (st == SQ_ERASE);
  assign arr_prog    = (st == SQ_WRITE) && flags[slot];
  assign done_pulse  = slot_adv && !fault && (slot == LAST);
  assign abort_pulse = busy && fault;

  // R5, R6: erase and program never overlap
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_erase, arr_prog}));
  // R7: a strobe only appears inside a stalled cycle
  a_r7_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_erase || arr_prog) |-> busy);
  // R6: erase phase always hands over to the slot pass
  a_r6_erase_to_write: assert property (@(posedge clk) disable iff (!rst_n)
    erase_end && !fault |=> busy && !arr_erase && slot == '0);

endmodule

// File: rtl/fpb_ctrl.sv
module fpb_ctrl #(
  parameter int unsigned PAGE_BYTES   = 64,
  parameter int unsigned ERASE_CYCLES = 20,
  parameter int unsigned PROG_CYCLES  = 4,
  localparam int unsigned IDX_W       = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W      = 16 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              cpu_stall,
  output logic              arr_erase,
  output logic              arr_prog,
  output logic [PAGE_W-1:0] arr_page,
  output logic [IDX_W-1:0]  arr_offset,
  output logic [7:0]        arr_wdata,
  input  logic              arr_fault
);
  import fpb_pkg::*;

  logic busy, done_pulse, abort_pulse;
  logic wr_ok, wr_cmd, wr_alo, wr_ahi, wr_dat;
  logic op_clear, op_start, op_erase, op_bad;
  logic err_q, done_q, mode_q;
  logic [7:0] alo, ahi, buf_rd;
  logic [IDX_W-1:0] idx, slot;
  logic [PAGE_BYTES-1:0] flags;

  // register decode: every write blocked while a cycle runs
  assign wr_ok  = reg_we && !busy;
  assign wr_cmd = wr_ok && (reg_sel == SEL_CTRL);
  assign wr_alo = wr_ok && (reg_sel == SEL_ALO);
  assign wr_ahi = wr_ok && (reg_sel == SEL_AHI);
  assign wr_dat = wr_ok && (reg_sel == SEL_DATA);

  assign op_clear = wr_cmd && (reg_wdata == OP_CLEAR);
  assign op_erase = wr_cmd && (reg_wdata == OP_ERPROG);
  assign op_start = op_erase || (wr_cmd && (reg_wdata == OP_PROG));
  assign op_bad   = wr_cmd && !op_clear && !op_start;

  fpb_regs #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_alo(wr_alo), .wr_ahi(wr_ahi), .wr_dat(wr_dat),
    .wdata(reg_wdata), .alo(alo), .ahi(ahi), .idx(idx), .page(arr_page)
  );

  fpb_buffer #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(op_clear), .wr(wr_dat), .wr_idx(idx),
    .wdata(reg_wdata), .rd_idx(idx), .rd_data(buf_rd), .pg_idx(slot),
    .pg_data(arr_wdata), .flags(flags)
  );

  fpb_seq #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W),
            .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(op_start), .start_erase(op_erase),
    .fault(arr_fault), .flags(flags), .busy(busy), .done_pulse(done_pulse),
    .abort_pulse(abort_pulse), .arr_erase(arr_erase), .arr_prog(arr_prog), .slot(slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (op_clear || op_start)  err_q <= 1'b0;
      else if (op_bad || abort_pulse) err_q <= 1'b1;
      if (op_clear || op_start)  done_q <= 1'b0;
      else if (done_pulse)       done_q <= 1'b1;
      if (op_start)              mode_q <= op_erase;
    end
  end

  assign cpu_stall  = busy;
  assign arr_offset = slot;

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = pack_status(busy, |flags, mode_q, done_q, err_q);
      SEL_ALO:  reg_rdata = alo;
      SEL_AHI:  reg_rdata = ahi;
      default:  reg_rdata = buf_rd;
    endcase
  end

  // R8: bad command raises the error and leaves the block idle
  a_r8_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    op_bad |=> err_q && !cpu_stall);
  // R9: address registers frozen against writes during a cycle
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && cpu_stall |=> $stable(alo) && $stable(ahi));
  // R10: fault ends the cycle with error and no done
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall && arr_fault |=> !cpu_stall && err_q && !done_q);
  // R5: the program strobe only lands on a marked slot
  a_r5_marked_only: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |-> flags[arr_offset]);

endmodule

// File: tb/tb_fpb_ctrl.sv
module tb_fpb_ctrl;
  localparam int E = 12;
  localparam int P = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic cpu_stall, arr_erase, arr_prog, arr_fault;
  logic [9:0] arr_page;
  logic [5:0] arr_offset;
  logic [7:0] arr_wdata;

  int n_chk = 0, n_bad = 0;
  logic [7:0] pmem [64];
  int busy_n, er_n, pg_n;
  logic page_ok;

  always #2.5 clk = ~clk;

  fpb_ctrl #(.PAGE_BYTES(64), .ERASE_CYCLES(E), .PROG_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_stall(cpu_stall),
    .arr_erase(arr_erase), .arr_prog(arr_prog), .arr_page(arr_page),
    .arr_offset(arr_offset), .arr_wdata(arr_wdata), .arr_fault(arr_fault)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  // run the busy window from the current negedge, modelling the array
  task automatic run_cycle(input logic [9:0] exp_page, input bit poke);
    busy_n = 0; er_n = 0; pg_n = 0; page_ok = 1'b1;
    while (cpu_stall && busy_n < 1000) begin
      if (arr_page != exp_page) page_ok = 1'b0;
      if (arr_erase) begin
        er_n++;
        for (int i = 0; i < 64; i++) pmem[i] = 8'hFF;
      end
      if (arr_prog) begin
        pg_n++;
        pmem[arr_offset] = arr_wdata;
      end
      busy_n++;
      if (poke && busy_n == 1) begin reg_sel = 2'd1; reg_we = 1'b1; reg_wdata = 8'h3F; end
      if (poke && busy_n == 2) begin reg_sel = 2'd0; reg_wdata = 8'h68; end
      if (poke && busy_n == 3) reg_we = 1'b0;
      @(negedge clk);
    end
    reg_we = 1'b0;
  endtask

  // {read, sel, data, expect, requirement}
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h00, 8'h00, 4'd2},  // clear
    {1'b0, 2'd1, 8'hBE, 8'h00, 4'd3},
    {1'b0, 2'd2, 8'h5A, 8'h00, 4'd3},
    {1'b0, 2'd3, 8'h11, 8'h00, 4'd3},  // slot 62
    {1'b1, 2'd1, 8'h00, 8'hBF, 4'd3},  // R3 increment
    {1'b0, 2'd3, 8'h22, 8'h00, 4'd3},  // slot 63
    {1'b1, 2'd1, 8'h00, 8'h80, 4'd3},  // R3 wrap keeps bits 7:6
    {1'b1, 2'd3, 8'h00, 8'h00, 4'd3},  // slot 0 untouched
    {1'b0, 2'd1, 8'hBE, 8'h00, 4'd3},
    {1'b1, 2'd3, 8'h00, 8'h11, 4'd3},  // R3 readback slot 62
    {1'b1, 2'd0, 8'h00, 8'h40, 4'd11}, // R11 staged bit
    {1'b0, 2'd0, 8'h00, 8'h00, 4'd2},
    {1'b1, 2'd3, 8'h00, 8'h00, 4'd2},  // R2 data cleared
    {1'b1, 2'd0, 8'h00, 8'h00, 4'd2},  // R2 flags cleared
    {1'b0, 2'd0, 8'h55, 8'h00, 4'd8},  // unknown command
    {1'b1, 2'd0, 8'h00, 8'h01, 4'd8}   // R8 error, not busy
  };

  initial begin
    #(5 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    arr_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 status", v, 8'h00);
    rd(2'd1, v); check("R1 alo", v, 8'h00);
    rd(2'd2, v); check("R1 ahi", v, 8'h00);
    rd(2'd3, v); check("R1 data", v, 8'h00);
    check("R1 strobes", {cpu_stall, arr_erase, arr_prog}, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][22]) begin
        rd(VEC[k][21:20], v);
        check($sformatf("vector %0d R%0d", k, VEC[k][3:0]), v, VEC[k][11:4]);
      end else wr(VEC[k][21:20], VEC[k][19:12]);
    end
    wr(2'd0, 8'h00);

    // program-only (R4, R5, R7, R11)
    for (int i = 0; i < 64; i++) pmem[i] = 8'h77;
    wr(2'd1, 8'hC5); wr(2'd2, 8'h3C);
    wr(2'd3, 8'hA1); wr(2'd3, 8'hB2);
    wr(2'd1, 8'hE0); wr(2'd3, 8'hC3);
    wr(2'd0, 8'h48);
    rd(2'd0, v); check("R7 busy status", v, 8'hC0);
    check("R7 stall", cpu_stall, 1);
    run_cycle(10'h0F3, 1'b0);
    check("R7 program duration", busy_n, 61 + 3 * P);
    check("R5 no erase", er_n, 0);
    check("R5 program cycles", pg_n, 3 * P);
    check("R4 page", page_ok, 1);
    check("R5 slot 5", pmem[5], 8'hA1);
    check("R5 slot 6", pmem[6], 8'hB2);
    check("R5 slot 32", pmem[32], 8'hC3);
    check("R5 unmarked kept", pmem[7], 8'h77);
    rd(2'd0, v); check("R11 status after program", v, 8'h42);

    // erase then program (R6)
    wr(2'd0, 8'h68);
    run_cycle(10'h0F3, 1'b0);
    check("R6 duration", busy_n, E + 61 + 3 * P);
    check("R6 erase cycles", er_n, E);
    check("R6 slot 32", pmem[32], 8'hC3);
    check("R6 unmarked erased", pmem[0], 8'hFF);
    check("R6 last erased", pmem[63], 8'hFF);
    rd(2'd0, v); check("R11 status after erase-program", v, 8'h52);

    // fault abort (R10)
    wr(2'd0, 8'h48);
    @(negedge clk); @(negedge clk);
    arr_fault = 1'b1;
    @(negedge clk);
    arr_fault = 1'b0;
    check("R10 stall released", cpu_stall, 0);
    rd(2'd0, v); check("R10 status", v, 8'h41);

    // writes during a cycle are ignored (R9)
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02); wr(2'd3, 8'h99);
    wr(2'd0, 8'h48);
    run_cycle(10'h000, 1'b1);
    check("R9 duration unchanged", busy_n, 63 + P);
    check("R9 no erase started", er_n, 0);
    rd(2'd1, v); check("R9 alo kept", v, 8'h03);
    rd(2'd0, v); check("R9 status", v, 8'h42);
    @(negedge clk);
    check("R9 no restart", cpu_stall, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule